// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital half of a 12-bit successive-approximation converter. A start request launches one conversion: the sampler is switched from track to hold, and the trial register is walked from its most significant bit downward. For each bit, the bit under test is set and every bit below it is cleared. The block waits for the trial to settle, then keeps or drops that bit according to a 1-bit comparator input. The trial word drives the DAC model, and the final word is latched into a result register.

Two inputs are captured at the start request. A short-cycle select stops the walk after the eight upper bits and leaves the four low result bits at zero. A mode select chooses one of two starts. In immediate mode, hold and the first trial begin at once. In delayed mode, an acquisition interval runs first, so an input that was still moving at the command has time to be acquired. All timing is counted in cycles of one internal clock: the settle cycles per trial, the acquisition cycles, and one cycle to latch the result before busy drops.

Top module: `sar_conv_seq`

## Requirements
- R1: After a synchronous reset, trial word and result are zero, busy is low and the hold control is low (track).
- R2: Each trial sets the bit under test to one with all lower bits zero, starting at the MSB. When the comparator input is high at the decision the bit stays one, otherwise it is cleared.
- R3: With an ideal comparator (high when the stimulus code is at least the trial word), a full conversion yields a result equal to the stimulus code.
- R4: Short-cycle select is captured at the start request. When captured high, only the eight upper trials run and result bits 3..0 are zero. Changing the select during the conversion has no effect.
- R5: Busy rises on the clock edge that accepts the start. It stays high for exactly ACQ + N*TRIAL_CYC + 1 cycles, where ACQ is ACQ_CYC in delayed mode and 0 in immediate mode, and N is 12 or 8. The result changes only on the edge where busy falls.
- R6: Start requests while busy is high are ignored, so a conversion is never restarted or shortened.
- R7: In immediate mode (mode select low at start), hold rises on the same edge as busy, and the first trial word (MSB only) appears with it.
- R8: In delayed mode (mode select high at start), hold stays low and the trial word stays zero for ACQ_CYC cycles after busy rises. Hold and the first trial then start together. Changing the mode select during the conversion has no effect.
- R9: Hold falls on the edge of the last bit decision, one cycle before busy falls.
- R10: Each trial lasts TRIAL_CYC cycles, and the comparator is sampled only in the last of them. Comparator values in the earlier cycles of a trial have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Convert request, sampled while idle |
| short_i | input | 1 | 1 = 8-bit short cycle, captured at start |
| delayed_i | input | 1 | 1 = acquisition interval before hold, captured at start |
| cmp_i | input | 1 | Comparator: 1 = input at or above trial word |
| trial_o | output | W | Trial word driving the DAC model |
| result_o | output | W | Latched conversion result |
| busy_o | output | 1 | High while a conversion is in progress |
| hold_o | output | 1 | Sampler control: 1 = hold, 0 = track |

## Verification
The bench builds the block with TRIAL_CYC = 3 and ACQ_CYC = 5 instead of the longer defaults. A conversion then takes a few dozen cycles, so many stimulus codes, both modes and both cycle lengths fit into one short run. A settle time above one cycle leaves room to drive a deliberately wrong comparator value in the non-decision cycles of every trial. It also leaves room to pulse start and flip both captured selects in the middle of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ACQ   = 2'd1,
        PH_TRIAL = 2'd2,
        PH_LATCH = 2'd3
    } phase_e;

    // One-cycle strobes from the controller to the datapath
    typedef struct packed {
        logic tmr_load;
        logic tr_clear;
        logic tr_first;
        logic tr_decide;
        logic tr_latch;
    } step_cmd_t;

    // Lowest bit index that receives a trial
    function automatic int unsigned stop_index(input logic short_cyc,
                                               input int unsigned width,
                                               input int unsigned short_bits);
        return short_cyc ? (width - short_bits) : 0;
    endfunction

endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int unsigned W  = 12,
    parameter int unsigned SB = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  step_cmd_t    cmd,
    input  logic         cmp_i,
    input  logic         short_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] result_o,
    output logic         last_o
);
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  trial_q, result_q, kept, keep_mask;
    logic [IW-1:0] idx_q, stop_idx;

    assign stop_idx = IW'(stop_index(short_i, W, SB));
    assign last_o   = (idx_q == stop_idx);

    generate
        for (genvar b = 0; b < W; b++) begin : g_mask
            if (b < W - SB) begin : g_low
                assign keep_mask[b] = ~short_i;
            end else begin : g_high
                assign keep_mask[b] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        kept = trial_q;
        if (!cmp_i)
            kept[idx_q] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q  <= '0;
            result_q <= '0;
            idx_q    <= '0;
        end else begin
            if (cmd.tr_first) begin
                trial_q <= {1'b1, {(W-1){1'b0}}};
                idx_q   <= IW'(W - 1);
            end else if (cmd.tr_clear) begin
                trial_q <= '0;
            end else if (cmd.tr_decide) begin
                if (last_o) begin
                    trial_q <= kept;
                end else begin
                    trial_q <= kept | (W'(1) << (idx_q - 1'b1));
                    idx_q   <= idx_q - 1'b1;
                end
            end
            if (cmd.tr_latch)
                result_q <= trial_q & keep_mask;
        end
    end

    assign trial_o  = trial_q;
    assign result_o = result_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned TRIAL_CYC = 4,
    parameter int unsigned ACQ_CYC   = 28,
    parameter int unsigned CW        = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          short_i,
    input  logic          delayed_i,
    input  logic          tmr_done,
    input  logic          last_bit,
    output step_cmd_t     cmd,
    output logic [CW-1:0] tmr_val,
    output logic          short_o,
    output logic          busy_o,
    output logic          hold_o
);
    phase_e phase_q, phase_d;
    logic   busy_q, hold_q, short_q;

    always_comb begin
        cmd     = '0;
        tmr_val = CW'(TRIAL_CYC - 1);
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (start_i) begin
                cmd.tmr_load = 1'b1;
                if (delayed_i) begin
                    cmd.tr_clear = 1'b1;
                    tmr_val      = CW'(ACQ_CYC - 1);
                    phase_d      = PH_ACQ;
                end else begin
                    cmd.tr_first = 1'b1;
                    phase_d      = PH_TRIAL;
                end
            end
            PH_ACQ: if (tmr_done) begin
                cmd.tmr_load = 1'b1;
                cmd.tr_first = 1'b1;
                phase_d      = PH_TRIAL;
            end
            PH_TRIAL: if (tmr_done) begin
                cmd.tr_decide = 1'b1;
                if (last_bit)
                    phase_d = PH_LATCH;
                else
                    cmd.tmr_load = 1'b1;
            end
            PH_LATCH: begin
                cmd.tr_latch = 1'b1;
                phase_d      = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
            hold_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_IDLE && start_i) begin
                busy_q  <= 1'b1;
                short_q <= short_i;
            end
            if (cmd.tr_latch)
                busy_q <= 1'b0;
            if (cmd.tr_first)
                hold_q <= 1'b1;
            else if (cmd.tr_decide && last_bit)
                hold_q <= 1'b0;
        end
    end

    assign short_o = short_q;
    assign busy_o  = busy_q;
    assign hold_o  = hold_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int unsigned W         = 12,
    parameter int unsigned SB        = 8,
    parameter int unsigned TRIAL_CYC = 4,
    parameter int unsigned ACQ_CYC   = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         short_i,
    input  logic         delayed_i,
    input  logic         cmp_i,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] result_o,
    output logic         busy_o,
    output logic         hold_o
);
    localparam int unsigned MAXLD = (ACQ_CYC > TRIAL_CYC) ? ACQ_CYC : TRIAL_CYC;
    localparam int unsigned CW    = $clog2(MAXLD + 1);

    step_cmd_t     cmd;
    logic [CW-1:0] tmr_val;
    logic          tmr_done, last_bit, short_lat;

    sar_seq_ctrl #(.TRIAL_CYC(TRIAL_CYC), .ACQ_CYC(ACQ_CYC), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
        .delayed_i(delayed_i), .tmr_done(tmr_done), .last_bit(last_bit),
        .cmd(cmd), .tmr_val(tmr_val), .short_o(short_lat),
        .busy_o(busy_o), .hold_o(hold_o)
    );

    sar_step_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(cmd.tmr_load), .load_val(tmr_val),
        .expired(tmr_done)
    );

    sar_trial_reg #(.W(W), .SB(SB)) u_trial (
        .clk(clk), .rst(rst), .cmd(cmd), .cmp_i(cmp_i), .short_i(short_lat),
        .trial_o(trial_o), .result_o(result_o), .last_o(last_bit)
    );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int unsigned W         = 12,
    parameter int unsigned SB        = 8,
    parameter int unsigned TRIAL_CYC = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         short_i,
    input logic [W-1:0] result_o,
    input logic         busy_o,
    input logic         hold_o
);
    logic        hold_prev, short_cap;
    logic [15:0] hold_len;
    logic [3:0]  hold_rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_prev  <= 1'b0;
            short_cap  <= 1'b0;
            hold_len   <= '0;
            hold_rises <= '0;
        end else begin
            hold_prev <= hold_o;
            if (!busy_o && start_i)
                short_cap <= short_i;
            hold_len <= hold_o ? hold_len + 1'b1 : '0;
            if (!busy_o)
                hold_rises <= '0;
            else if (hold_o && !hold_prev)
                hold_rises <= hold_rises + 1'b1;
        end
    end

    // R9
    hold_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |=> $fell(busy_o));

    // R5
    result_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> $stable(result_o));

    // R7
    hold_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> busy_o);

    // R10
    trial_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> (hold_len == 16'((short_cap ? SB : W) * TRIAL_CYC)));

    // R4
    short_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && short_cap) |-> (result_o[W-SB-1:0] == '0));

    // R6
    single_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (hold_rises == 4'd1));
endmodule

bind sar_conv_seq sar_seq_chk #(.W(W), .SB(SB), .TRIAL_CYC(TRIAL_CYC)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
    .result_o(result_o), .busy_o(busy_o), .hold_o(hold_o)
);

// File: tb/sar_conv_seq_tb_top.sv
module sar_conv_seq_tb_top;
    localparam int W   = 12;
    localparam int SB  = 8;
    localparam int TC  = 3;
    localparam int ACQ = 5;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 1'b0, short_i = 1'b0, delayed_i = 1'b0, cmp_i;
    logic [W-1:0] trial_o, result_o;
    logic busy_o, hold_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int stim_v = 0;
    bit glitch = 1'b0;
    bit live = 1'b0;

    // reference model state
    int m_phase = 0, m_cnt = 0, m_bit = 0, m_trial = 0, m_result = 0;
    bit m_busy = 0, m_hold = 0, m_short = 0;
    int nt;

    always #4 clk = ~clk;

    sar_conv_seq #(.W(W), .SB(SB), .TRIAL_CYC(TC), .ACQ_CYC(ACQ)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
        .delayed_i(delayed_i), .cmp_i(cmp_i), .trial_o(trial_o),
        .result_o(result_o), .busy_o(busy_o), .hold_o(hold_o)
    );

    // ideal comparator, optionally wrong outside the decision cycle
    assign cmp_i = (stim_v >= m_trial) ^ (glitch && !(m_phase == 2 && m_cnt == 0));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= 0; m_cnt <= 0; m_bit <= 0; m_trial <= 0; m_result <= 0;
            m_busy <= 0; m_hold <= 0; m_short <= 0;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                    m_busy  <= 1;
                    m_short <= short_i;
                    if (delayed_i) begin
                        m_phase <= 1; m_cnt <= ACQ - 1; m_trial <= 0;
                    end else begin
                        m_phase <= 2; m_cnt <= TC - 1; m_hold <= 1;
                        m_bit <= W - 1; m_trial <= 1 << (W - 1);
                    end
                end
                1: if (m_cnt == 0) begin
                    m_phase <= 2; m_cnt <= TC - 1; m_hold <= 1;
                    m_bit <= W - 1; m_trial <= 1 << (W - 1);
                end else m_cnt <= m_cnt - 1;
                2: if (m_cnt == 0) begin
                    nt = (stim_v >= m_trial) ? m_trial : m_trial - (1 << m_bit);
                    if (m_bit == (m_short ? W - SB : 0)) begin
                        m_trial <= nt; m_hold <= 0; m_phase <= 3;
                    end else begin
                        m_trial <= nt + (1 << (m_bit - 1));
                        m_bit <= m_bit - 1; m_cnt <= TC - 1;
                    end
                end else m_cnt <= m_cnt - 1;
                default: begin
                    m_result <= m_trial; m_busy <= 0; m_phase <= 0;
                end
            endcase
        end
    end

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (live) begin
            check(trial_o == W'(m_trial), "R2 trial word", trial_o, m_trial);
            check(busy_o == m_busy, "R5 busy", busy_o, m_busy);
            check(hold_o == m_hold, "R7 R8 R9 hold", hold_o, m_hold);
            check(result_o == W'(m_result), "R3 result", result_o, m_result);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_conv(input int stim, input bit sh, input bit dl,
                            input bit gl, input bit poke);
        int busy_n, hold_wait, exp_res, exp_len;
        bit seen_hold;
        busy_n = 0; hold_wait = 0; seen_hold = 0;
        @(negedge clk);
        stim_v = stim; short_i = sh; delayed_i = dl; glitch = gl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) begin
            if (!hold_o && !seen_hold) hold_wait++;
            else seen_hold = 1;
            if (poke && (busy_n % 3 == 1)) begin
                start_i = 1'b1; short_i = ~sh; delayed_i = ~dl;
            end else begin
                start_i = 1'b0;
            end
            busy_n++;
            @(negedge clk);
        end
        start_i = 1'b0; glitch = 1'b0;
        exp_res = sh ? (stim & ~((1 << (W - SB)) - 1)) : stim;
        exp_len = (dl ? ACQ : 0) + (sh ? SB : W) * TC + 1;
        // R3 R4 R10: final code from the ideal comparator
        check(result_o == W'(exp_res), sh ? "R4 short result" : "R3 full result",
              result_o, exp_res);
        // R5 R6: busy length unaffected by extra starts
        check(busy_n == exp_len, poke ? "R6 busy length" : "R5 busy length",
              busy_n, exp_len);
        // R7 R8: cycles before hold
        check(hold_wait == (dl ? ACQ : 0), dl ? "R8 acquisition delay" : "R7 immediate hold",
              hold_wait, dl ? ACQ : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(trial_o == '0, "R1 trial", trial_o, 0);
        check(result_o == '0, "R1 result", result_o, 0);
        check(busy_o == 1'b0, "R1 busy", busy_o, 0);
        check(hold_o == 1'b0, "R1 hold", hold_o, 0);
        rst = 1'b0;
        live = 1'b1;
        @(negedge clk);
        run_conv(12'hA5C, 0, 0, 0, 0);
        run_conv(12'h000, 0, 0, 0, 0);
        run_conv(12'hFFF, 0, 0, 0, 0);
        run_conv(12'h7B9, 1, 0, 0, 1);   // R4 select flipped mid-run
        run_conv(12'h123, 0, 1, 0, 1);   // R8 mode flipped mid-run
        run_conv(12'hFFF, 1, 1, 0, 0);
        run_conv(12'h800, 0, 0, 0, 1);   // R6 repeated starts
        run_conv(12'h3C7, 0, 0, 1, 0);   // R10 wrong comparator off-decision
        run_conv(12'h00F, 1, 1, 1, 0);   // R10 with short cycle
        run_conv(12'h7FF, 0, 1, 1, 1);
        repeat (4) @(negedge clk);
        // R5 result held while idle
        check(result_o == 12'h7FF, "R5 idle result", result_o, 12'h7FF);
        live = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule